// File: doc/BRIEF.md
# Two-Level Interrupt Nesting Arbiter

This block decides, at each instruction boundary, whether the CPU core takes an interrupt and which one it takes. Each maskable source has a request line, a mask bit and a priority bit that selects one of two levels. There is also one non-maskable request line. Requests are latched into pending flags. A pending flag is cleared only when its source is acknowledged, so a request that cannot be taken yet waits until it can.

The arbiter owns three flags. The global enable flag gates all maskable acceptance. The in-service priority flag is 0 while a high-level handler runs. The non-maskable busy flag is set while the non-maskable handler runs. During the acknowledge cycle the flag outputs still show their values from before the acknowledge, so the core can save them. A return pulse loads saved values back into the flags.

A request at the same level as the handler in service, or at a higher level, may nest when enable is set. Within one level, the lowest source index wins. After a return, at least one main-program instruction completes before anything else is taken.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset, enable is 0, the in-service priority flag is 1, the non-maskable busy flag is 0, no request is pending and no acknowledge is given.
- R2: A pulse on `req_i[i]` sets pending bit i at the next edge. The bit stays set until source i is acknowledged and is cleared at the edge that ends the acknowledge cycle. If a new request for the same source arrives in that same cycle, the bit stays set.
- R3: `ack_o` is high for one cycle and only in a cycle with `insn_done_i` high. `ack_vec_o` is 0 for the non-maskable source and i+1 for maskable source i.
- R4: A maskable source is never acknowledged while enable is 0 or while its mask bit is 1. It stays pending.
- R5: Acknowledging any request clears enable. `ei_i` sets enable and `di_i` clears it. In a cycle where an acknowledge and `ei_i` coincide, enable ends up 0.
- R6: Priority bit 0 means the high level and 1 means the low level. Acknowledging a high-level source sets the in-service priority flag to 0. Acknowledging a low-level source sets it to 1. A non-maskable acknowledge leaves it unchanged.
- R7: When the in-service priority flag is 0, only high-level sources are taken and low-level sources stay pending. When it is 1, a high-level source is chosen over a low-level one. Equal-level nesting is allowed.
- R8: Among eligible sources of the chosen level, the lowest index is acknowledged.
- R9: A pending non-maskable request is taken regardless of enable and the mask bits. It wins over maskable sources, sets the non-maskable busy flag and has its own pending bit on `nmi_pend_o`.
- R10: While the non-maskable busy flag is 1, no acknowledge of any kind is given, including for a new non-maskable request.
- R11: `reti_i` loads enable from `ret_ie_i` and the in-service priority flag from `ret_isp_i`, and clears the non-maskable busy flag.
- R12: No acknowledge is given in a `reti_i` cycle or at the first `insn_done_i` that follows it. The strobe after that one may acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Maskable request pulses |
| mask_i | input | N_SRC | Per-source mask, 1 = masked |
| prio_i | input | N_SRC | Per-source level, 0 = high, 1 = low |
| nmi_i | input | 1 | Non-maskable request pulse |
| insn_done_i | input | 1 | Instruction boundary strobe |
| ei_i | input | 1 | Set enable |
| di_i | input | 1 | Clear enable |
| reti_i | input | 1 | Return from a handler |
| ret_ie_i | input | 1 | Saved enable value restored on return |
| ret_isp_i | input | 1 | Saved in-service priority value restored on return |
| ack_o | output | 1 | Acknowledge pulse |
| ack_vec_o | output | 5 | Vector of the acknowledged source |
| pend_o | output | N_SRC | Maskable pending flags |
| nmi_pend_o | output | 1 | Non-maskable pending flag |
| ie_o | output | 1 | Enable flag |
| isp_o | output | 1 | In-service priority flag |
| nmi_busy_o | output | 1 | Non-maskable handler active |

## Verification
The hardest cases to reach are those where a request is refused and stays pending, and is then taken once state changes through the block's own flags. Examples are a low-level request parked under a high-level handler, or a non-maskable request held while the non-maskable handler runs, both released only after a return and the one-instruction gap. Directed sequences build these nestings step by step: acknowledge, re-enable, send a blocked request, return with chosen saved values, then apply two strobes. Seeded random traffic with sparse returns and non-maskable pulses then mixes levels, masks and coincident request and acknowledge cycles. A cycle-level bench model checks every output.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int unsigned VEC_W = 5;
  localparam logic [VEC_W-1:0] NMI_VEC = '0;

  typedef enum logic [1:0] {
    GNT_NONE,
    GNT_NMI,
    GNT_HI,
    GNT_LO
  } grant_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[i] <= 1'b0;
      else if (set_i[i]) pend_o[i] <= 1'b1;   // new request beats clear
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_o[i] && !clr_i[i] |=> pend_o[i]);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned IDX_W = 5
) (
  input  logic [N_SRC-1:0] cand_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_SRC-1:0] onehot_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign onehot_o = cand_i & (~cand_i + 1'b1);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned IDX_W = VEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             insn_done_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             reti_i,
  input  logic             ret_ie_i,
  input  logic             ret_isp_i,
  input  logic             hi_hit_i,
  input  logic [IDX_W-1:0] hi_idx_i,
  input  logic             lo_hit_i,
  input  logic [IDX_W-1:0] lo_idx_i,
  output grant_e           grant_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ie_o,
  output logic             isp_o,
  output logic             busy_o,
  output logic             nmi_pend_o
);
  logic ie_q, isp_q, busy_q, gap_q, nmi_pend_q;
  logic take, mask_ok;

  assign take    = insn_done_i && !reti_i && !gap_q;
  assign mask_ok = take && !busy_q && !nmi_pend_q && ie_q;

  always_comb begin
    grant_o = GNT_NONE;
    if (take && nmi_pend_q && !busy_q)  grant_o = GNT_NMI;
    else if (mask_ok && hi_hit_i)       grant_o = GNT_HI;
    else if (mask_ok && lo_hit_i && isp_q) grant_o = GNT_LO;
  end

  always_comb begin
    unique case (grant_o)
      GNT_HI:  vec_o = VEC_W'(hi_idx_i) + 1'b1;
      GNT_LO:  vec_o = VEC_W'(lo_idx_i) + 1'b1;
      default: vec_o = NMI_VEC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q       <= 1'b0;
      isp_q      <= 1'b1;
      busy_q     <= 1'b0;
      gap_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      if (grant_o != GNT_NONE) ie_q <= 1'b0;
      else if (reti_i)         ie_q <= ret_ie_i;
      else if (di_i)           ie_q <= 1'b0;
      else if (ei_i)           ie_q <= 1'b1;

      if (grant_o == GNT_HI)      isp_q <= 1'b0;
      else if (grant_o == GNT_LO) isp_q <= 1'b1;
      else if (reti_i)            isp_q <= ret_isp_i;

      if (grant_o == GNT_NMI) busy_q <= 1'b1;
      else if (reti_i)        busy_q <= 1'b0;

      // the strobe closing the return instruction takes nothing
      if (reti_i && !insn_done_i) gap_q <= 1'b1;
      else if (insn_done_i)       gap_q <= 1'b0;

      if (nmi_i)                   nmi_pend_q <= 1'b1;
      else if (grant_o == GNT_NMI) nmi_pend_q <= 1'b0;
    end
  end

  assign ie_o       = ie_q;
  assign isp_o      = isp_q;
  assign busy_o     = busy_q;
  assign nmi_pend_o = nmi_pend_q;

  assert_ie_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o != GNT_NONE |=> !ie_q);
  assert_hi_isp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o == GNT_HI |=> !isp_q);
  assert_nmi_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o == GNT_NMI |=> busy_o);
  assert_busy_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> grant_o == GNT_NONE);
  assert_gap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q || reti_i |-> grant_o == GNT_NONE);
  assert_low_park_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isp_q |-> grant_o != GNT_LO);
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_nest_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             nmi_i,
  input  logic             insn_done_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             reti_i,
  input  logic             ret_ie_i,
  input  logic             ret_isp_i,
  output logic             ack_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic [N_SRC-1:0] pend_o,
  output logic             nmi_pend_o,
  output logic             ie_o,
  output logic             isp_o,
  output logic             nmi_busy_o
);
  localparam int unsigned N_LVL = 2;

  logic [N_SRC-1:0]              pend, clr;
  logic [N_LVL-1:0][N_SRC-1:0]   lvl_cand, lvl_oh;
  logic [N_LVL-1:0]              lvl_hit;
  logic [N_LVL-1:0][VEC_W-1:0]   lvl_idx;
  grant_e                        grant;

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign lvl_cand[0] = pend & ~mask_i & ~prio_i;
  assign lvl_cand[1] = pend & ~mask_i &  prio_i;

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    irq_pick #(.N_SRC(N_SRC), .IDX_W(VEC_W)) u_pick (
      .cand_i   (lvl_cand[l]),
      .hit_o    (lvl_hit[l]),
      .idx_o    (lvl_idx[l]),
      .onehot_o (lvl_oh[l])
    );
  end

  irq_nest_ctrl #(.IDX_W(VEC_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nmi_i       (nmi_i),
    .insn_done_i (insn_done_i),
    .ei_i        (ei_i),
    .di_i        (di_i),
    .reti_i      (reti_i),
    .ret_ie_i    (ret_ie_i),
    .ret_isp_i   (ret_isp_i),
    .hi_hit_i    (lvl_hit[0]),
    .hi_idx_i    (lvl_idx[0]),
    .lo_hit_i    (lvl_hit[1]),
    .lo_idx_i    (lvl_idx[1]),
    .grant_o     (grant),
    .vec_o       (ack_vec_o),
    .ie_o        (ie_o),
    .isp_o       (isp_o),
    .busy_o      (nmi_busy_o),
    .nmi_pend_o  (nmi_pend_o)
  );

  always_comb begin
    unique case (grant)
      GNT_HI:  clr = lvl_oh[0];
      GNT_LO:  clr = lvl_oh[1];
      default: clr = '0;
    endcase
  end

  assign ack_o  = grant != GNT_NONE;
  assign pend_o = pend;

  assert_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> insn_done_i);
  assert_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o || insn_done_i);
  assert_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && ack_vec_o != NMI_VEC |-> ie_o);
  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && ack_vec_o != NMI_VEC && req_i == '0 |=> $countones(pend_o) < $countones($past(pend_o)));
endmodule

// File: tb/sim_irq_nest_arb.sv
module sim_irq_nest_arb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req, mask, prio;
  logic nmi, insn_done, ei, di, reti, ret_ie, ret_isp;
  logic ack_o;
  logic [4:0] ack_vec_o;
  logic [N-1:0] pend_o;
  logic nmi_pend_o, ie_o, isp_o, nmi_busy_o;

  int checks = 0;
  int errors = 0;

  bit [N-1:0] m_pend;
  bit m_nmi, m_ie, m_isp, m_busy, m_gap;

  always #4 clk = ~clk;

  irq_nest_arb #(.N_SRC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mask_i(mask), .prio_i(prio),
    .nmi_i(nmi), .insn_done_i(insn_done), .ei_i(ei), .di_i(di), .reti_i(reti),
    .ret_ie_i(ret_ie), .ret_isp_i(ret_isp), .ack_o(ack_o), .ack_vec_o(ack_vec_o),
    .pend_o(pend_o), .nmi_pend_o(nmi_pend_o), .ie_o(ie_o), .isp_o(isp_o),
    .nmi_busy_o(nmi_busy_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    req = '0; nmi = 0; insn_done = 0; ei = 0; di = 0;
    reti = 0; ret_ie = 0; ret_isp = 0;
  endtask

  function automatic void model_eval(output bit a, output int v);
    a = 0; v = 0;
    if (!insn_done || reti || m_gap) return;
    if (m_nmi && !m_busy) begin a = 1; v = 0; return; end
    if (m_busy || !m_ie) return;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && !mask[i] && !prio[i]) begin a = 1; v = i + 1; return; end
    if (m_isp)
      for (int i = 0; i < N; i++)
        if (m_pend[i] && !mask[i] && prio[i]) begin a = 1; v = i + 1; return; end
  endfunction

  task automatic cyc();
    bit a;
    int v;
    bit [N-1:0] clr;
    #1;
    model_eval(a, v);
    chk("R3 ack", 32'(ack_o), 32'(a));
    if (a) chk("R8 vector", 32'(ack_vec_o), 32'(v));
    chk("R5 enable", 32'(ie_o), 32'(m_ie));
    chk("R6 isp", 32'(isp_o), 32'(m_isp));
    chk("R10 busy", 32'(nmi_busy_o), 32'(m_busy));
    chk("R2 pending", 32'(pend_o), 32'(m_pend));
    chk("R9 nmi pending", 32'(nmi_pend_o), 32'(m_nmi));
    @(posedge clk);
    clr = '0;
    if (a && v != 0) clr[v-1] = 1'b1;
    m_pend = (m_pend & ~clr) | req;
    m_nmi  = (m_nmi && !(a && v == 0)) || nmi;
    if (a) m_ie = 0; else if (reti) m_ie = ret_ie; else if (di) m_ie = 0; else if (ei) m_ie = 1;
    if (a && v != 0) m_isp = prio[v-1]; else if (reti) m_isp = ret_isp;
    if (a && v == 0) m_busy = 1; else if (reti) m_busy = 0;
    if (reti && !insn_done) m_gap = 1; else if (insn_done) m_gap = 0;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    mask = '0;
    prio = 8'hF0;
    m_pend = '0; m_nmi = 0; m_ie = 0; m_isp = 1; m_busy = 0; m_gap = 0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 ie", 32'(ie_o), 0);
    chk("R1 isp", 32'(isp_o), 1);
    chk("R1 busy", 32'(nmi_busy_o), 0);
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 ack", 32'(ack_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    req = 8'h04; cyc();
    insn_done = 1; #1 chk("R4 disabled no ack", 32'(ack_o), 0); cyc();
    ei = 1; cyc();
    mask = 8'h04; insn_done = 1; #1 chk("R4 masked no ack", 32'(ack_o), 0); cyc();
    mask = 8'h00; insn_done = 1; #1;
    chk("R3 ack", 32'(ack_o), 1); chk("R3 vec", 32'(ack_vec_o), 3); cyc();
    chk("R5 ie cleared", 32'(ie_o), 0);
    chk("R6 isp high", 32'(isp_o), 0);
    chk("R2 cleared", 32'(pend_o), 0);

    ei = 1; cyc();
    req = 8'h20; cyc();
    insn_done = 1; #1 chk("R7 low parked", 32'(ack_o), 0); cyc();
    chk("R7 still pending", 32'(pend_o), 32'h20);
    reti = 1; ret_ie = 1; ret_isp = 1; cyc();
    chk("R11 ie", 32'(ie_o), 1); chk("R11 isp", 32'(isp_o), 1);
    insn_done = 1; #1 chk("R12 gap", 32'(ack_o), 0); cyc();
    insn_done = 1; #1;
    chk("R12 taken", 32'(ack_o), 1); chk("R12 vec", 32'(ack_vec_o), 6); cyc();
    chk("R6 isp low", 32'(isp_o), 1);

    ei = 1; req = 8'h0A; cyc();
    insn_done = 1; req = 8'h02; #1;
    chk("R8 lowest", 32'(ack_vec_o), 2); chk("R7 high over low", 32'(ack_o), 1); cyc();
    chk("R2 set wins", 32'(pend_o), 32'h0A);
    ei = 1; cyc();
    insn_done = 1; #1 chk("R7 equal nests", 32'(ack_vec_o), 2); cyc();

    nmi = 1; cyc();
    insn_done = 1; #1;
    chk("R9 nmi ack", 32'(ack_o), 1); chk("R9 nmi vec", 32'(ack_vec_o), 0); cyc();
    chk("R9 busy", 32'(nmi_busy_o), 1);
    ei = 1; nmi = 1; cyc();
    insn_done = 1; #1 chk("R10 blocked", 32'(ack_o), 0); cyc();
    reti = 1; ret_ie = 1; ret_isp = 1; cyc();
    chk("R11 busy cleared", 32'(nmi_busy_o), 0);
    insn_done = 1; #1 chk("R12 gap after nmi", 32'(ack_o), 0); cyc();
    insn_done = 1; #1;
    chk("R9 nmi first", 32'(ack_o), 1); chk("R9 vec0", 32'(ack_vec_o), 0); cyc();

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(15) == 0) mask = 8'($urandom) & 8'($urandom);
      if ($urandom_range(31) == 0) prio = 8'($urandom);
      req       = ($urandom_range(3) == 0) ? (8'(1) << $urandom_range(N-1)) : '0;
      nmi       = ($urandom_range(63) == 0);
      insn_done = $urandom_range(1);
      ei        = ($urandom_range(5) == 0);
      di        = ($urandom_range(19) == 0);
      reti      = ($urandom_range(11) == 0);
      ret_ie    = $urandom_range(1);
      ret_isp   = $urandom_range(1);
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule